// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps every in-flight instruction of an out-of-order core in program order, so that results computed early and out of order become architecturally visible strictly in sequence. Issue logic allocates one entry per instruction. The index of that entry is returned as the result tag. Functional units later broadcast their results under that tag. The oldest entry retires through a single register write port, or as a store pulse, once its result is present.

Results that have completed but have not yet retired can be read back by architectural register number. A register status table remembers the youngest pending producer of each register. A completion that carries a nonzero fault code is held in its entry. The fault is acted on only when that entry becomes the oldest, which gives a precise exception. When a branch resolves as mispredicted, every entry younger than it is discarded and fetch is redirected.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1 and `alloc_tag` is 0. `commit_we`, `commit_store`, `exc_valid` and `redirect_valid` are 0, and no register reports a pending producer.
- R2: Only the oldest entry retires, and only once its result has arrived. An entry of kind 0 (register) then asserts `commit_we` with its destination and value for exactly one cycle. A younger entry that has completed waits for all older entries to retire first.
- R3: Each accepted allocation returns in `alloc_tag` the index of the entry it occupies. Indices run upward by one, modulo ENTRIES.
- R4: A broadcast on `cdb_valid` with `cdb_tag` naming a live entry stores `cdb_value` and `cdb_exc` in that entry and marks it done from the next cycle on.
- R5: For `src_reg`, `src_pending` reports whether a live register-writing entry targets that register, and `src_tag` names the youngest such entry. `src_ready` and `src_value` give that entry's result once it is done. When the producer retires, the register is no longer pending.
- R6: With ENTRIES entries live, `alloc_ready` is 0 and a request on `alloc_valid` is ignored: it takes no entry and shifts no later tag.
- R7: Kind 1 (store) retires with a one-cycle `commit_store` pulse and no register write. Kind 2 (branch) retires with neither.
- R8: A nonzero `cdb_exc` is not reported while older entries are live. When the faulting entry is oldest, `exc_valid` is 1 with `exc_code` and the entry's `exc_pc`, and no register write occurs for it.
- R9: The cycle after an exception is reported, every entry is gone and `redirect_valid` is 1 with `redirect_pc` equal to HANDLER_PC. The next allocation gets tag 0, and no register stays pending.
- R10: A `mispredict_valid` naming a live branch tag discards every younger entry, so none of them ever retires. In that cycle `alloc_ready` is 0 (the flush wins over allocation). The next cycle `redirect_valid` is 1 with `mispredict_pc`, and the next allocation gets the branch tag plus one. Older entries still retire in order.
- R11: After a mispredict flush, the register status table names the youngest surviving producer of each register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests an entry |
| alloc_ready | output | 1 | An entry can be taken this cycle |
| alloc_kind | input | 2 | 0 register, 1 store, 2 branch |
| alloc_dst | input | AREG_W | Destination architectural register |
| alloc_pc | input | PC_W | Instruction address |
| alloc_tag | output | IDX_W | Entry index given to the instruction |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | IDX_W | Entry the result belongs to |
| cdb_value | input | DATA_W | Result value |
| cdb_exc | input | EXC_W | Fault code, 0 means none |
| src_reg | input | AREG_W | Register looked up for an operand |
| src_pending | output | 1 | A live entry will write that register |
| src_ready | output | 1 | That producer has completed |
| src_tag | output | IDX_W | Youngest producer entry |
| src_value | output | DATA_W | Producer result when ready, else 0 |
| commit_we | output | 1 | Architectural register write |
| commit_dst | output | AREG_W | Register written |
| commit_value | output | DATA_W | Value written |
| commit_store | output | 1 | Oldest store retires |
| exc_valid | output | 1 | Oldest entry faulted |
| exc_code | output | EXC_W | Its fault code |
| exc_pc | output | PC_W | Its instruction address |
| mispredict_valid | input | 1 | A branch resolved wrongly |
| mispredict_tag | input | IDX_W | Entry of that branch |
| mispredict_pc | input | PC_W | Correct successor address |
| redirect_valid | output | 1 | Fetch restart request |
| redirect_pc | output | PC_W | Fetch restart address |

## Verification
Two functions meet in one cycle. A mispredict flush arrives together with a pending allocation request and with the result broadcast of the branch itself. The bench holds `alloc_valid` high in that cycle and expects `alloc_ready` to be low. It then confirms that the request left no trace: the next tag granted is the branch tag plus one, and neither younger instruction ever shows up at the commit port. A scoreboard queue of expected retirements, each a register write, a store or a fault, is compared in order against what the commit and exception ports produce. Any output that the queue does not predict counts as a miscompare.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } kind_e;
endpackage

// File: rtl/rob_remap.sv
// Rebuilds the register status table from the live register writers, oldest first.
module rob_remap #(
    parameter int ENTRIES = 8,
    parameter int AREG_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int NREGS  = 1 << AREG_W
) (
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [ENTRIES-1:0] live,
    input  logic [AREG_W-1:0] dst [ENTRIES],
    output logic [NREGS-1:0]  busy,
    output logic [IDX_W-1:0]  tag [NREGS]
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        busy = '0;
        idx  = '0;
        for (int r = 0; r < NREGS; r++) tag[r] = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            idx = head_idx + IDX_W'(k);
            if (live[idx]) begin
                busy[dst[idx]] = 1'b1;
                tag[dst[idx]]  = idx;
            end
        end
    end
endmodule

// File: rtl/rob_src_port.sv
// Operand lookup: finds the pending producer of a register and its result.
module rob_src_port #(
    parameter int ENTRIES = 8,
    parameter int AREG_W  = 3,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int NREGS  = 1 << AREG_W
) (
    input  logic [AREG_W-1:0] src_reg,
    input  logic [NREGS-1:0]  busy,
    input  logic [IDX_W-1:0]  tag [NREGS],
    input  logic [ENTRIES-1:0] done,
    input  logic [DATA_W-1:0] value [ENTRIES],
    output logic              src_pending,
    output logic              src_ready,
    output logic [IDX_W-1:0]  src_tag,
    output logic [DATA_W-1:0] src_value
);
    always_comb begin
        src_pending = busy[src_reg];
        src_tag     = tag[src_reg];
        src_ready   = src_pending && done[src_tag];
        src_value   = src_ready ? value[src_tag] : '0;
    end
endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import rob_pkg::*;
#(
    parameter int          ENTRIES    = 8,
    parameter int          AREG_W     = 3,
    parameter int          DATA_W     = 16,
    parameter int          PC_W       = 16,
    parameter int          EXC_W      = 3,
    parameter int unsigned HANDLER_PC = 32'h0000_0F00,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int PTR_W = IDX_W + 1,
    localparam int NREGS = 1 << AREG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [1:0]        alloc_kind,
    input  logic [AREG_W-1:0] alloc_dst,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic [IDX_W-1:0]  alloc_tag,
    input  logic              cdb_valid,
    input  logic [IDX_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic [EXC_W-1:0]  cdb_exc,
    input  logic [AREG_W-1:0] src_reg,
    output logic              src_pending,
    output logic              src_ready,
    output logic [IDX_W-1:0]  src_tag,
    output logic [DATA_W-1:0] src_value,
    output logic              commit_we,
    output logic [AREG_W-1:0] commit_dst,
    output logic [DATA_W-1:0] commit_value,
    output logic              commit_store,
    output logic              exc_valid,
    output logic [EXC_W-1:0]  exc_code,
    output logic [PC_W-1:0]   exc_pc,
    input  logic              mispredict_valid,
    input  logic [IDX_W-1:0]  mispredict_tag,
    input  logic [PC_W-1:0]   mispredict_pc,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc
);
    typedef struct packed {
        logic              valid;
        logic              done;
        logic [1:0]        kind;
        logic [AREG_W-1:0] dst;
        logic [DATA_W-1:0] value;
        logic [EXC_W-1:0]  exc;
        logic [PC_W-1:0]   pc;
    } entry_t;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic             redir_v;
        logic [PC_W-1:0]  redir_pc;
    } ctrl_t;

    entry_t ent_q [ENTRIES];
    entry_t ent_d [ENTRIES];
    ctrl_t  c_q, c_d;
    logic [NREGS-1:0] map_busy_q, map_busy_d;
    logic [IDX_W-1:0] map_tag_q [NREGS];
    logic [IDX_W-1:0] map_tag_d [NREGS];

    logic [IDX_W-1:0]  head_idx, tail_idx, head_idx_d, br_off, fl_idx;
    logic [PTR_W-1:0]  occupancy;
    logic              head_ready, exc_take, commit_fire, flush_br, alloc_fire;
    entry_t            head_e;
    logic [ENTRIES-1:0] live_d, done_q;
    logic [AREG_W-1:0] dst_d [ENTRIES];
    logic [DATA_W-1:0] val_q [ENTRIES];

    // Retirement and flush decisions
    always_comb begin
        head_idx    = c_q.head[IDX_W-1:0];
        tail_idx    = c_q.tail[IDX_W-1:0];
        occupancy   = c_q.tail - c_q.head;
        head_e      = ent_q[head_idx];
        head_ready  = head_e.valid && head_e.done;
        exc_take    = head_ready && (head_e.exc != '0);
        commit_fire = head_ready && !exc_take;
        flush_br    = mispredict_valid && !exc_take && ent_q[mispredict_tag].valid;
        alloc_ready = (occupancy != PTR_W'(ENTRIES)) && !mispredict_valid && !exc_take;
        alloc_fire  = alloc_valid && alloc_ready;
        br_off      = mispredict_tag - head_idx;
    end

    // Next-state computation
    always_comb begin
        ent_d = ent_q;
        c_d   = c_q;
        c_d.redir_v = 1'b0;
        fl_idx = '0;

        if (cdb_valid && ent_q[cdb_tag].valid) begin
            ent_d[cdb_tag].done  = 1'b1;
            ent_d[cdb_tag].value = cdb_value;
            ent_d[cdb_tag].exc   = cdb_exc;
        end

        if (commit_fire) begin
            ent_d[head_idx].valid = 1'b0;
            c_d.head = c_q.head + 1'b1;
        end

        if (alloc_fire) begin
            ent_d[tail_idx] = '{valid: 1'b1, done: 1'b0, kind: alloc_kind,
                                dst: alloc_dst, value: '0, exc: '0, pc: alloc_pc};
            c_d.tail = c_q.tail + 1'b1;
        end

        if (flush_br) begin
            for (int k = 1; k < ENTRIES; k++) begin
                fl_idx = head_idx + IDX_W'(k);
                if (k > int'(br_off)) ent_d[fl_idx].valid = 1'b0;
            end
            c_d.tail     = c_q.head + PTR_W'(br_off) + 1'b1;
            c_d.redir_v  = 1'b1;
            c_d.redir_pc = mispredict_pc;
        end

        if (exc_take) begin
            for (int k = 0; k < ENTRIES; k++) ent_d[k].valid = 1'b0;
            c_d.head     = '0;
            c_d.tail     = '0;
            c_d.redir_v  = 1'b1;
            c_d.redir_pc = PC_W'(HANDLER_PC);
        end

        head_idx_d = c_d.head[IDX_W-1:0];
        for (int k = 0; k < ENTRIES; k++) begin
            live_d[k] = ent_d[k].valid && (kind_e'(ent_d[k].kind) == KIND_REG);
            dst_d[k]  = ent_d[k].dst;
            done_q[k] = ent_q[k].valid && ent_q[k].done;
            val_q[k]  = ent_q[k].value;
        end
    end

    rob_remap #(.ENTRIES(ENTRIES), .AREG_W(AREG_W)) u_remap (
        .head_idx (head_idx_d),
        .live     (live_d),
        .dst      (dst_d),
        .busy     (map_busy_d),
        .tag      (map_tag_d)
    );

    rob_src_port #(.ENTRIES(ENTRIES), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_src (
        .src_reg     (src_reg),
        .busy        (map_busy_q),
        .tag         (map_tag_q),
        .done        (done_q),
        .value       (val_q),
        .src_pending (src_pending),
        .src_ready   (src_ready),
        .src_tag     (src_tag),
        .src_value   (src_value)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q        <= '0;
            map_busy_q <= '0;
            for (int k = 0; k < ENTRIES; k++) ent_q[k] <= '0;
            for (int r = 0; r < NREGS; r++) map_tag_q[r] <= '0;
        end else begin
            c_q        <= c_d;
            map_busy_q <= map_busy_d;
            for (int k = 0; k < ENTRIES; k++) ent_q[k] <= ent_d[k];
            for (int r = 0; r < NREGS; r++) map_tag_q[r] <= map_tag_d[r];
        end
    end

    always_comb begin
        alloc_tag      = tail_idx;
        commit_we      = commit_fire && (kind_e'(head_e.kind) == KIND_REG);
        commit_store   = commit_fire && (kind_e'(head_e.kind) == KIND_STORE);
        commit_dst     = head_e.dst;
        commit_value   = head_e.value;
        exc_valid      = exc_take;
        exc_code       = head_e.exc;
        exc_pc         = head_e.pc;
        redirect_valid = c_q.redir_v;
        redirect_pc    = c_q.redir_pc;
    end
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 16,
    parameter int PTR_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             commit_we,
    input logic             commit_store,
    input logic             exc_valid,
    input logic             mispredict_valid,
    input logic [PC_W-1:0]  mispredict_pc,
    input logic             redirect_valid,
    input logic [PC_W-1:0]  redirect_pc,
    input logic [PTR_W-1:0] head_q,
    input logic [PTR_W-1:0] tail_q
);
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q - head_q) <= PTR_W'(ENTRIES));

    // R6
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tail_q - head_q) == PTR_W'(ENTRIES)) |-> !alloc_ready);

    // R2
    commit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |=> (head_q == PTR_W'($past(head_q) + 1'b1)));

    // R7
    store_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_store |-> (!commit_we && !exc_valid));

    // R9
    exc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (redirect_valid && head_q == tail_q));

    // R10
    mispredict_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mispredict_valid && !exc_valid) |=>
            (redirect_valid && redirect_pc == $past(mispredict_pc)));

    // R10
    flush_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_valid |-> !alloc_ready);
endmodule

bind spec_rob rob_chk #(.ENTRIES(ENTRIES), .PC_W(PC_W), .PTR_W(PTR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .alloc_ready      (alloc_ready),
    .commit_we        (commit_we),
    .commit_store     (commit_store),
    .exc_valid        (exc_valid),
    .mispredict_valid (mispredict_valid),
    .mispredict_pc    (mispredict_pc),
    .redirect_valid   (redirect_valid),
    .redirect_pc      (redirect_pc),
    .head_q           (c_q.head),
    .tail_q           (c_q.tail)
);

// File: tb/sim_spec_rob.sv
module sim_spec_rob;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, alloc_ready;
    logic [1:0]  alloc_kind = '0;
    logic [2:0]  alloc_dst = '0;
    logic [15:0] alloc_pc = '0;
    logic [2:0]  alloc_tag;
    logic        cdb_valid = 1'b0;
    logic [2:0]  cdb_tag = '0;
    logic [15:0] cdb_value = '0;
    logic [2:0]  cdb_exc = '0;
    logic [2:0]  src_reg = '0;
    logic        src_pending, src_ready;
    logic [2:0]  src_tag;
    logic [15:0] src_value;
    logic        commit_we, commit_store, exc_valid;
    logic [2:0]  commit_dst, exc_code;
    logic [15:0] commit_value, exc_pc;
    logic        mispredict_valid = 1'b0;
    logic [2:0]  mispredict_tag = '0;
    logic [15:0] mispredict_pc = '0;
    logic        redirect_valid;
    logic [15:0] redirect_pc;

    int nchk = 0, nfail = 0;
    int exp_tag = 0;

    typedef struct { int kind; int a; int b; string req; } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    spec_rob u0 (.*);

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(int kind, int a, int b, string req);
        item_t it;
        it.kind = kind; it.a = a; it.b = b; it.req = req;
        q.push_back(it);
    endtask

    task automatic alloc(int kind, int dst, int pc);
        alloc_valid = 1'b1; alloc_kind = 2'(kind); alloc_dst = 3'(dst); alloc_pc = 16'(pc);
        @(negedge clk);
        check("R3 alloc_tag", int'(alloc_tag), exp_tag);
        check("R3 alloc_ready", int'(alloc_ready), 1);
        tick();
        alloc_valid = 1'b0;
        exp_tag = (exp_tag + 1) % 8;
    endtask

    task automatic complete(int tag, int val, int exc);
        cdb_valid = 1'b1; cdb_tag = 3'(tag); cdb_value = 16'(val); cdb_exc = 3'(exc);
        tick();
        cdb_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (q.size() != 0 && n < 200) begin tick(); n++; end
        check("R2 drained", q.size(), 0);
        tick();
    endtask

    task automatic lookup(string req, int r, int pend, int tag, int rdy, int val);
        src_reg = 3'(r);
        @(negedge clk);
        check({req, " src_pending"}, int'(src_pending), pend);
        if (pend != 0) check({req, " src_tag"}, int'(src_tag), tag);
        check({req, " src_ready"}, int'(src_ready), rdy);
        if (rdy != 0) check({req, " src_value"}, int'(src_value), val);
        tick();
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (commit_we || commit_store || exc_valid)) begin
            if (q.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL R2/R10 unexpected retirement actual=we%0b st%0b ex%0b expected=none",
                         commit_we, commit_store, exc_valid);
            end else begin
                item_t it;
                it = q.pop_front();
                if (commit_we) begin
                    check({it.req, " kind"}, 0, it.kind);
                    check({it.req, " commit_dst"}, int'(commit_dst), it.a);
                    check({it.req, " commit_value"}, int'(commit_value), it.b);
                end else if (commit_store) begin
                    check({it.req, " store kind"}, 1, it.kind);
                end else begin
                    check({it.req, " exc kind"}, 2, it.kind);
                    check({it.req, " exc_code"}, int'(exc_code), it.a);
                    check({it.req, " exc_pc"}, int'(exc_pc), it.b);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 alloc_ready", int'(alloc_ready), 1);
        check("R1 alloc_tag", int'(alloc_tag), 0);
        check("R1 commit_we", int'(commit_we), 0);
        check("R1 commit_store", int'(commit_store), 0);
        check("R1 exc_valid", int'(exc_valid), 0);
        check("R1 redirect_valid", int'(redirect_valid), 0);
        check("R1 src_pending", int'(src_pending), 0);
        tick();

        // R2 R4 R5: out-of-order completion, in-order retirement, operand lookup
        push(0, 1, 'hA1, "R2 first"); alloc(0, 1, 'h100);
        push(0, 2, 'hB2, "R2 second"); alloc(0, 2, 'h104);
        push(0, 1, 'hC3, "R2 third"); alloc(0, 1, 'h108);
        lookup("R5 youngest", 1, 1, 2, 0, 0);
        lookup("R5 other", 2, 1, 1, 0, 0);
        complete(2, 'hC3, 0);
        @(negedge clk);
        check("R2 younger done waits", int'(commit_we), 0);
        tick();
        lookup("R4 done value", 1, 1, 2, 1, 'hC3);
        complete(0, 'hA1, 0);
        complete(1, 'hB2, 0);
        drain();
        lookup("R5 cleared after retire", 1, 0, 0, 0, 0);

        // R6: full buffer backpressure, ignored request
        for (int i = 0; i < 8; i++) begin
            push(0, i, 'h200 + i, "R6 full run");
            alloc(0, i, 'h200 + 4 * i);
        end
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dst = 3'd7;
        @(negedge clk);
        check("R6 alloc_ready when full", int'(alloc_ready), 0);
        tick(); tick();
        alloc_valid = 1'b0;
        for (int i = 7; i >= 0; i--) complete((3 + i) % 8, 'h200 + i, 0);
        drain();

        // R7: store and branch retirement; R3 tag after ignored request
        push(1, 0, 0, "R7 store"); alloc(1, 0, 'h400);
        alloc(2, 0, 'h404);
        push(0, 3, 'h77, "R7 after branch"); alloc(0, 3, 'h408);
        complete(5, 'h77, 0);
        complete(4, 0, 0);
        complete(3, 'h1234, 0);
        drain();

        // R10 R11: mispredict flush colliding with an allocation request
        push(0, 4, 'h44, "R10 older V"); alloc(0, 4, 'h4FC);
        push(0, 3, 'h33, "R10 older X"); alloc(0, 3, 'h500);
        alloc(2, 0, 'h504);
        alloc(0, 4, 'h508);
        alloc(0, 3, 'h50C);
        complete(1, 'hE1, 0);
        complete(2, 'hE2, 0);
        complete(7, 'h33, 0);
        cdb_valid = 1'b1; cdb_tag = 3'd0; cdb_value = '0; cdb_exc = '0;
        mispredict_valid = 1'b1; mispredict_tag = 3'd0; mispredict_pc = 16'h0600;
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dst = 3'd5;
        @(negedge clk);
        check("R10 alloc_ready during flush", int'(alloc_ready), 0);
        tick();
        cdb_valid = 1'b0; mispredict_valid = 1'b0; alloc_valid = 1'b0;
        @(negedge clk);
        check("R10 redirect_valid", int'(redirect_valid), 1);
        check("R10 redirect_pc", int'(redirect_pc), 'h600);
        tick();
        lookup("R11 survivor of r4", 4, 1, 6, 0, 0);
        lookup("R11 survivor of r3", 3, 1, 7, 1, 'h33);
        exp_tag = 1;
        complete(6, 'h44, 0);
        drain();

        // R8 R9: deferred precise exception
        push(0, 5, 'h55, "R8 older commit"); alloc(0, 5, 'h700);
        push(2, 3, 'h704, "R8 fault"); alloc(0, 6, 'h704);
        alloc(0, 7, 'h708);
        complete(2, 0, 3);
        complete(3, 'h99, 0);
        @(negedge clk);
        check("R8 deferred while older live", int'(exc_valid), 0);
        tick();
        complete(1, 'h55, 0);
        begin
            int n = 0;
            @(negedge clk);
            while (!exc_valid && n < 50) begin @(negedge clk); n++; end
        end
        @(posedge clk); #1;
        @(negedge clk);
        check("R9 redirect_valid", int'(redirect_valid), 1);
        check("R9 redirect_pc", int'(redirect_pc), 'hF00);
        tick();
        lookup("R9 table cleared", 7, 0, 0, 0, 0);
        exp_tag = 0;
        push(0, 2, 'h5A, "R9 restart"); alloc(0, 2, 'hF00);
        complete(0, 'h5A, 0);
        drain();

        summary();
        $finish;
    end
endmodule